// File: doc/BRIEF.md
# Floating-Point Multiply Special-Case Resolver

This block sits ahead of a floating-point mantissa multiplier and settles every operand combination that does not need arithmetic. For each operand it receives a class code (zero, finite number, infinity, quiet NaN, signalling NaN) and a sign bit. It ranks the two classes, moves the higher-ranked operand into the "Y" role, and then walks a fixed priority list. The result is the class and sign of the product, plus a marker telling the datapath which input a propagated NaN came from, or that a default NaN is needed. It also produces a two-bit exception mask and a start strobe for the multiply datapath when both operands are finite non-zero numbers.

All decisions are combinational. The outputs are registered one cycle after the operands are presented. The exception mask is meant to be ORed into an external sticky status register, so it is forced to zero on every cycle without a valid operation.

Top module: `fpm_special_resolver`

## Requirements
- R1: Outputs appear one clock after the inputs. `res_valid` equals the previous cycle's `op_valid`. When `op_valid` was low, every other output is zero.
- R2: Class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN. If either operand is a NaN, the result class is that NaN's class and the sign is the XOR of both signs. `exc_flags` bit 0 (NaN operand) is set, and `mul_go` stays low.
- R3: If exactly one operand is a signalling NaN, that operand is the result, whichever input it arrives on. `res_from_b` is 1 when the propagated NaN is operand B and 0 when it is operand A.
- R4: If both operands have the same NaN class, operand B is propagated (`res_from_b` = 1). For any result that is not a propagated NaN, `res_from_b` is 0.
- R5: Infinity times zero, in either order, gives class 3 with `res_dnan` = 1, sign equal to parameter `DNAN_SIGN` (default 0), and `exc_flags` = 2'b10.
- R6: Infinity times a number or an infinity gives class 2 with the XOR of the signs and no flags.
- R7: Zero times zero or a number gives class 0 with the XOR of the signs and no flags.
- R8: Number times number gives class 1, the XOR of the signs, `mul_go` = 1 and no flags.
- R9: `mul_go` is high only in the R8 case. At most one flag bit is set for any result. `res_dnan` is high only in the R5 case.
- R10: Class codes 5 to 7 are treated as quiet NaN (class 3), with the same ranking.
- R11: A synchronous active-high reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operand pair present |
| a_cls | input | 3 | Class code of operand A |
| a_sign | input | 1 | Sign of operand A |
| b_cls | input | 3 | Class code of operand B |
| b_sign | input | 1 | Sign of operand B |
| res_valid | output | 1 | Result valid |
| res_cls | output | 3 | Result class code |
| res_sign | output | 1 | Result sign |
| res_from_b | output | 1 | Propagated NaN is operand B |
| res_dnan | output | 1 | Result is the default NaN |
| mul_go | output | 1 | Start the mantissa multiply |
| exc_flags | output | 2 | bit0 NaN operand, bit1 infinity times zero |

## Verification
The bench targets mixed NaN pairs in both operand orders. A wrong ranking or a swap in the wrong direction would propagate the quiet NaN instead of the signalling one, or flip `res_from_b`. It tries infinity against zero from both sides, where a broken priority list would return infinity or zero with no invalid flag. It also tries NaN against infinity and NaN against zero, where a design testing infinity before NaN would raise the wrong flag. Unused class codes, an idle cycle following a valid one, and a reset in mid-stream round out the cases. These show a design that leaks flags into the sticky mask or fails to fold the spare codes into quiet NaN.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int CLS_W  = 3;
    localparam int FLAG_W = 2;
    localparam int FLG_NAN_OP  = 0;
    localparam int FLG_INF_ZRO = 1;

    typedef enum logic [CLS_W-1:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } cls_e;

    typedef struct packed {
        cls_e cls;
        logic sign;
    } opnd_t;

    typedef struct packed {
        cls_e              cls;
        logic              sign;
        logic              from_b;
        logic              dnan;
        logic              go;
        logic [FLAG_W-1:0] flags;
    } res_t;

    localparam res_t RES_IDLE = '{cls: CLS_ZERO, sign: 1'b0, from_b: 1'b0,
                                  dnan: 1'b0, go: 1'b0, flags: '0};

    // Fold unused codes into quiet NaN.
    function automatic cls_e norm_cls(input logic [CLS_W-1:0] raw);
        cls_e c;
        if (raw > CLS_W'(CLS_SNAN)) c = CLS_QNAN;
        else                        c = cls_e'(raw);
        return c;
    endfunction

    // Rank: zero < number < infinity < quiet NaN < signalling NaN.
    function automatic logic [CLS_W-1:0] cls_rank(input cls_e c);
        logic [CLS_W-1:0] r;
        case (c)
            CLS_ZERO: r = 3'd0;
            CLS_NUM:  r = 3'd1;
            CLS_INF:  r = 3'd2;
            CLS_QNAN: r = 3'd3;
            default:  r = 3'd4;
        endcase
        return r;
    endfunction

    function automatic logic is_nan(input cls_e c);
        return (c == CLS_QNAN) || (c == CLS_SNAN);
    endfunction

endpackage

// File: rtl/fpm_order.sv
module fpm_order
    import fpm_pkg::*;
(
    input  logic [CLS_W-1:0] a_cls_raw,
    input  logic             a_sign,
    input  logic [CLS_W-1:0] b_cls_raw,
    input  logic             b_sign,
    output opnd_t            x_o,
    output opnd_t            y_o,
    output logic             y_is_b
);
    opnd_t a_op, b_op;
    logic  swap;

    always_comb begin
        a_op.cls  = norm_cls(a_cls_raw);
        a_op.sign = a_sign;
        b_op.cls  = norm_cls(b_cls_raw);
        b_op.sign = b_sign;
        // Equal ranks keep B in the Y role.
        swap   = cls_rank(a_op.cls) > cls_rank(b_op.cls);
        x_o    = swap ? b_op : a_op;
        y_o    = swap ? a_op : b_op;
        y_is_b = ~swap;
    end
endmodule

// File: rtl/fpm_decide.sv
module fpm_decide
    import fpm_pkg::*;
#(
    parameter logic DNAN_SIGN = 1'b0
) (
    input  opnd_t x_i,
    input  opnd_t y_i,
    input  logic  y_is_b,
    output res_t  res_o
);
    logic sgn_x;

    always_comb begin
        sgn_x = x_i.sign ^ y_i.sign;
        res_o = RES_IDLE;
        if (is_nan(y_i.cls)) begin
            res_o.cls               = y_i.cls;
            res_o.sign              = sgn_x;
            res_o.from_b            = y_is_b;
            res_o.flags[FLG_NAN_OP] = 1'b1;
        end else if (y_i.cls == CLS_INF) begin
            if (x_i.cls == CLS_ZERO) begin
                res_o.cls                = CLS_QNAN;
                res_o.sign               = DNAN_SIGN;
                res_o.dnan               = 1'b1;
                res_o.flags[FLG_INF_ZRO] = 1'b1;
            end else begin
                res_o.cls  = CLS_INF;
                res_o.sign = sgn_x;
            end
        end else if (x_i.cls == CLS_ZERO) begin
            res_o.cls  = CLS_ZERO;
            res_o.sign = sgn_x;
        end else begin
            res_o.cls  = CLS_NUM;
            res_o.sign = sgn_x;
            res_o.go   = 1'b1;
        end
    end
endmodule

// File: rtl/fpm_special_resolver.sv
module fpm_special_resolver
    import fpm_pkg::*;
#(
    parameter logic DNAN_SIGN = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [CLS_W-1:0] a_cls,
    input  logic             a_sign,
    input  logic [CLS_W-1:0] b_cls,
    input  logic             b_sign,
    output logic             res_valid,
    output logic [CLS_W-1:0] res_cls,
    output logic             res_sign,
    output logic             res_from_b,
    output logic             res_dnan,
    output logic             mul_go,
    output logic [FLAG_W-1:0] exc_flags
);
    opnd_t x_op, y_op;
    logic  y_is_b;
    res_t  res_c, res_q;
    logic  vld_q;

    fpm_order u_order (
        .a_cls_raw (a_cls),
        .a_sign    (a_sign),
        .b_cls_raw (b_cls),
        .b_sign    (b_sign),
        .x_o       (x_op),
        .y_o       (y_op),
        .y_is_b    (y_is_b)
    );

    fpm_decide #(.DNAN_SIGN(DNAN_SIGN)) u_decide (
        .x_i    (x_op),
        .y_i    (y_op),
        .y_is_b (y_is_b),
        .res_o  (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= RES_IDLE;
        end else begin
            vld_q <= op_valid;
            res_q <= op_valid ? res_c : RES_IDLE;
        end
    end

    assign res_valid  = vld_q;
    assign res_cls    = res_q.cls;
    assign res_sign   = res_q.sign;
    assign res_from_b = res_q.from_b;
    assign res_dnan   = res_q.dnan;
    assign mul_go     = res_q.go;
    assign exc_flags  = res_q.flags;
endmodule

// File: rtl/fpm_special_chk.sv
module fpm_special_chk
    import fpm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [CLS_W-1:0]  a_cls,
    input logic [CLS_W-1:0]  b_cls,
    input logic              res_valid,
    input logic [CLS_W-1:0]  res_cls,
    input logic              res_dnan,
    input logic              mul_go,
    input logic [FLAG_W-1:0] exc_flags
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && exc_flags == '0 && !mul_go && !res_dnan));

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R2
    nan_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (a_cls >= 3'd3 || b_cls >= 3'd3)) |=> (exc_flags == 2'b01 && !mul_go));

    // R5
    inf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && ((a_cls == 3'd2 && b_cls == 3'd0) || (a_cls == 3'd0 && b_cls == 3'd2)))
        |=> (exc_flags == 2'b10 && res_dnan && res_cls == 3'd3));

    // R8
    go_num_chk: assert property (@(posedge clk) disable iff (rst)
        mul_go |-> (res_cls == 3'd1 && exc_flags == '0 && res_valid));

    // R9
    flag_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(exc_flags));

    // R9
    dnan_only_chk: assert property (@(posedge clk) disable iff (rst)
        res_dnan |-> exc_flags == 2'b10);
endmodule

bind fpm_special_resolver fpm_special_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .a_cls     (a_cls),
    .b_cls     (b_cls),
    .res_valid (res_valid),
    .res_cls   (res_cls),
    .res_dnan  (res_dnan),
    .mul_go    (mul_go),
    .exc_flags (exc_flags)
);

// File: tb/sim_fpm_special_resolver.sv
module sim_fpm_special_resolver;
    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [2:0] a_cls, b_cls;
    logic       a_sign, b_sign;
    logic       res_valid, res_sign, res_from_b, res_dnan, mul_go;
    logic [2:0] res_cls;
    logic [1:0] exc_flags;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    fpm_special_resolver u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid),
        .a_cls(a_cls), .a_sign(a_sign), .b_cls(b_cls), .b_sign(b_sign),
        .res_valid(res_valid), .res_cls(res_cls), .res_sign(res_sign),
        .res_from_b(res_from_b), .res_dnan(res_dnan), .mul_go(mul_go),
        .exc_flags(exc_flags)
    );

    // {valid, a_cls, a_s, b_cls, b_s, | cls, sign, from_b, dnan, go, flags[1:0]}
    localparam int NV = 21;
    localparam logic [17:0] VEC [NV] = '{
        {1'b1,3'd1,1'b0,3'd1,1'b1, 3'd1,1'b1,1'b0,1'b0,1'b1,2'b00},
        {1'b1,3'd1,1'b1,3'd1,1'b1, 3'd1,1'b0,1'b0,1'b0,1'b1,2'b00},
        {1'b1,3'd0,1'b1,3'd1,1'b0, 3'd0,1'b1,1'b0,1'b0,1'b0,2'b00},
        {1'b1,3'd1,1'b0,3'd0,1'b0, 3'd0,1'b0,1'b0,1'b0,1'b0,2'b00},
        {1'b1,3'd0,1'b1,3'd0,1'b1, 3'd0,1'b0,1'b0,1'b0,1'b0,2'b00},
        {1'b1,3'd2,1'b0,3'd1,1'b1, 3'd2,1'b1,1'b0,1'b0,1'b0,2'b00},
        {1'b1,3'd1,1'b1,3'd2,1'b1, 3'd2,1'b0,1'b0,1'b0,1'b0,2'b00},
        {1'b1,3'd2,1'b1,3'd2,1'b0, 3'd2,1'b1,1'b0,1'b0,1'b0,2'b00},
        {1'b1,3'd2,1'b0,3'd0,1'b0, 3'd3,1'b0,1'b0,1'b1,1'b0,2'b10},
        {1'b1,3'd0,1'b1,3'd2,1'b1, 3'd3,1'b0,1'b0,1'b1,1'b0,2'b10},
        {1'b1,3'd3,1'b1,3'd1,1'b0, 3'd3,1'b1,1'b0,1'b0,1'b0,2'b01},
        {1'b1,3'd1,1'b1,3'd4,1'b0, 3'd4,1'b1,1'b1,1'b0,1'b0,2'b01},
        {1'b1,3'd4,1'b0,3'd3,1'b1, 3'd4,1'b1,1'b0,1'b0,1'b0,2'b01},
        {1'b1,3'd3,1'b0,3'd4,1'b0, 3'd4,1'b0,1'b1,1'b0,1'b0,2'b01},
        {1'b1,3'd3,1'b1,3'd3,1'b0, 3'd3,1'b1,1'b1,1'b0,1'b0,2'b01},
        {1'b1,3'd4,1'b0,3'd4,1'b0, 3'd4,1'b0,1'b1,1'b0,1'b0,2'b01},
        {1'b1,3'd0,1'b0,3'd3,1'b1, 3'd3,1'b1,1'b1,1'b0,1'b0,2'b01},
        {1'b1,3'd2,1'b1,3'd3,1'b0, 3'd3,1'b1,1'b1,1'b0,1'b0,2'b01},
        {1'b1,3'd5,1'b0,3'd1,1'b0, 3'd3,1'b0,1'b0,1'b0,1'b0,2'b01},
        {1'b1,3'd7,1'b1,3'd4,1'b0, 3'd4,1'b1,1'b1,1'b0,1'b0,2'b01},
        {1'b0,3'd2,1'b1,3'd0,1'b1, 3'd0,1'b0,1'b0,1'b0,1'b0,2'b00}
    };

    function automatic string tag_of(input int i);
        if (i < 2)       return "R8";
        else if (i < 5)  return "R7";
        else if (i < 8)  return "R6";
        else if (i < 10) return "R5";
        else if (i < 11) return "R2";
        else if (i < 14) return "R3";
        else if (i < 16) return "R4";
        else if (i < 18) return "R2";
        else if (i < 20) return "R10";
        else             return "R1";
    endfunction

    task automatic check_out(input string tag, input logic vexp,
                             input logic [8:0] exp);
        logic [8:0] act;
        act = {res_cls, res_sign, res_from_b, res_dnan, mul_go, exc_flags};
        total++;
        if (res_valid !== vexp || act !== exp) begin
            bad++;
            $display("FAIL %s: got valid=%b out=%b expected valid=%b out=%b",
                     tag, res_valid, act, vexp, exp);
        end
    endtask

    initial begin
        rst = 1'b1; op_valid = 1'b0;
        a_cls = 3'd0; b_cls = 3'd0; a_sign = 1'b0; b_sign = 1'b0;
        repeat (3) @(negedge clk);
        // R11: outputs clear under reset
        check_out("R11", 1'b0, 9'd0);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            {op_valid, a_cls, a_sign, b_cls, b_sign} = VEC[i][17:9];
            @(negedge clk);
            // R1: result one clock after the operands
            check_out(tag_of(i), VEC[i][17], VEC[i][8:0]);
        end
        // R1: idle cycle right after a flagged operation clears the mask
        op_valid = 1'b1; a_cls = 3'd4; b_cls = 3'd1; a_sign = 1'b0; b_sign = 1'b0;
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        check_out("R1", 1'b0, 9'd0);
        // R9: number pair after an invalid keeps go alone
        op_valid = 1'b1; a_cls = 3'd1; b_cls = 3'd1; a_sign = 1'b1; b_sign = 1'b0;
        @(negedge clk);
        check_out("R9", 1'b1, {3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00});
        // R11: reset mid-stream
        op_valid = 1'b1; a_cls = 3'd2; b_cls = 3'd0;
        rst = 1'b1;
        @(negedge clk);
        check_out("R11", 1'b0, 9'd0);
        rst = 1'b0; op_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule